// File: doc/BRIEF.md
# GPIO Bank Interrupt Event Detector

This block watches every input line of one GPIO bank and turns selected conditions into a single interrupt request for the bank. Each pin has a 32-bit control word that picks which conditions count: transitions and steady levels seen on the raw synchronised input, and the same four conditions seen on a debounced copy of the input. Edge conditions are held in per-pin latches until software clears them with a command bit. Level conditions follow the pin directly and are never held.

A per-pin override field can pass the combined event, invert it, or force it low or high. The result is then gated by a bank-wide enable register that has one bit per pin. The gated bits form the bank status vector. The request line is high while any status bit is high. Both the control words and the enable register are written through four write modes: plain write, toggle, set and clear.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, every control word, edge latch and enable bit is zero. As a result `irq_status` and `irq_req` are low.
- R2: The enable register holds one bit per pin. Status bit p is the pin's override result ANDed with enable bit p. A write with `reg_tgt`=1 updates the enable register from `reg_wdata[NPINS-1:0]`. The `reg_alias` value selects the mode: 0 replaces the register, 1 toggles the given bits, 2 sets them and 3 clears them.
- R3: `irq_req` is high exactly when at least one `irq_status` bit is high.
- R4: Control bit 20 enables falling-edge detection and bit 21 enables rising-edge detection on the raw input. An edge is a pin level that differs from the level sampled at the previous clock edge; that sampled level resets low. An enabled edge latches at the clock edge that sees it and holds until cleared. If both bits are set, either transition latches.
- R5: Control bit 22 makes a low pin level an event and bit 23 makes a high pin level an event. Both follow the pin in the same cycle and are not latched.
- R6: Bits 24 (falling), 25 (rising), 26 (low) and 27 (high) enable the same four conditions on a filtered level. The filtered level resets low. It takes the pin's value only after the pin has differed from it at FILT_LEN consecutive clock edges, so a shorter pulse never reaches it.
- R7: A control write with `reg_wdata[28]`=1 and any `reg_alias` other than 3 clears all four edge latches of that pin. The bit is not stored. If an enabled edge is detected in the same cycle as this command, the latch stays set.
- R8: Control bits [31:30] override the OR of the pin's latched edges and active levels: 0 passes it, 1 inverts it, 2 forces it low, 3 forces it high. The override is applied before the enable mask.
- R9: A control write with `reg_tgt`=0 goes to the pin selected by `reg_pin` and uses the same four modes as R2. Only bits 20 to 27 and 30 to 31 are stored. A `reg_pin` value of NPINS or more changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_lvl | input | NPINS | Synchronised pin levels |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_tgt | input | 1 | Write target: 0 selects a pin control word, 1 selects the enable register |
| reg_alias | input | 2 | Write mode: 0 write, 1 toggle, 2 set, 3 clear |
| reg_pin | input | PIDX_W | Pin index for control word writes |
| reg_wdata | input | 32 | Write data |
| irq_status | output | NPINS | Bank status: override result gated by enable |
| irq_req | output | 1 | Bank interrupt request |

## Verification
The bench builds the block with NPINS=6 and FILT_LEN=4. Six pins leave room for one pin per source class: raw edge, double edge, level, filtered edge, override and same-cycle clear. With these values the 3-bit pin index can also address indices 6 and 7, which do not exist, so the write-ignore path can be reached. A filter length of four keeps the debounce boundary short enough to probe on both sides: a 4-cycle hold latches and a 2-cycle pulse does not.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int WORD_W = 32;

  // write modes shared by control words and the enable register
  typedef enum logic [1:0] {
    MODE_WRITE  = 2'd0,
    MODE_TOGGLE = 2'd1,
    MODE_SET    = 2'd2,
    MODE_CLEAR  = 2'd3
  } wr_mode_e;

  // control word field positions
  localparam int SRC_LO  = 20;
  localparam int SRC_HI  = 27;
  localparam int KILL_B  = 28;
  localparam int OVR_LO  = 30;
  localparam int OVR_HI  = 31;
  localparam int NSRC    = SRC_HI - SRC_LO + 1;

  // source enable indices within the stored enable byte
  localparam int S_FALL  = 0;
  localparam int S_RISE  = 1;
  localparam int S_LOW   = 2;
  localparam int S_HIGH  = 3;
  localparam int S_FFALL = 4;
  localparam int S_FRISE = 5;
  localparam int S_FLOW  = 6;
  localparam int S_FHIGH = 7;

  // override codes
  typedef enum logic [1:0] {
    OVR_PASS = 2'd0,
    OVR_INV  = 2'd1,
    OVR_LOW  = 2'd2,
    OVR_HIGH = 2'd3
  } ovr_e;

  typedef struct packed {
    logic [1:0]      ovr;
    logic [NSRC-1:0] src;
  } pin_cfg_t;

  localparam int CFG_W = $bits(pin_cfg_t);

  function automatic logic [CFG_W-1:0] mode_merge(
    input logic [CFG_W-1:0] cur,
    input logic [CFG_W-1:0] wd,
    input logic [1:0]       mode
  );
    logic [CFG_W-1:0] res;
    case (mode)
      MODE_WRITE:  res = wd;
      MODE_TOGGLE: res = cur ^ wd;
      MODE_SET:    res = cur | wd;
      default:     res = cur & ~wd;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/gpio_evt_filter.sv
module gpio_evt_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_in,
  output logic filt_q,
  output logic f_rise,
  output logic f_fall
);
  localparam int CNT_W = (FILT_LEN > 2) ? $clog2(FILT_LEN) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_LEN - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             filt_d;

  always_comb begin
    cnt_d  = '0;
    filt_d = filt_q;
    if (lvl_in != filt_q) begin
      if (cnt_q == CNT_LAST) begin
        filt_d = lvl_in;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      filt_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      filt_q <= filt_d;
    end
  end

  assign f_rise = filt_d & ~filt_q;
  assign f_fall = ~filt_d & filt_q;

endmodule

// File: rtl/gpio_evt_pin.sv
module gpio_evt_pin
  import gpio_irq_pkg::*;
#(
  parameter int FILT_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lvl_in,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_mode,
  input  logic [WORD_W-1:0] cfg_wdata,
  output logic              event_o
);
  localparam int NLAT = 4;

  pin_cfg_t        cfg_q, cfg_d;
  logic            prev_q;
  logic [NLAT-1:0] lat_q, lat_d;
  logic            filt_lvl, f_rise, f_fall;
  logic            kill_cmd;
  logic [NLAT-1:0] det, det_en;
  logic            ev_raw;

  gpio_evt_filter #(.FILT_LEN(FILT_LEN)) u_filt (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_in (lvl_in),
    .filt_q (filt_lvl),
    .f_rise (f_rise),
    .f_fall (f_fall)
  );

  // configuration next state
  always_comb begin
    cfg_d = mode_merge(cfg_q,
                       {cfg_wdata[OVR_HI:OVR_LO], cfg_wdata[SRC_HI:SRC_LO]},
                       cfg_mode);
  end

  assign kill_cmd = cfg_we && (cfg_mode != MODE_CLEAR) && cfg_wdata[KILL_B];

  // latch order: raw fall, raw rise, filtered fall, filtered rise
  assign det    = {f_rise, f_fall, lvl_in & ~prev_q, ~lvl_in & prev_q};
  assign det_en = {cfg_q.src[S_FRISE], cfg_q.src[S_FFALL],
                   cfg_q.src[S_RISE],  cfg_q.src[S_FALL]};

  always_comb begin
    lat_d = lat_q;
    if (kill_cmd) begin
      lat_d = '0;
    end
    lat_d = lat_d | (det & det_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_we) begin
      cfg_q <= cfg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      lat_q  <= '0;
    end else begin
      prev_q <= lvl_in;
      lat_q  <= lat_d;
    end
  end

  // combined event and override
  always_comb begin
    ev_raw = (|lat_q)
           | (cfg_q.src[S_LOW]   & ~lvl_in)
           | (cfg_q.src[S_HIGH]  &  lvl_in)
           | (cfg_q.src[S_FLOW]  & ~filt_lvl)
           | (cfg_q.src[S_FHIGH] &  filt_lvl);
    case (cfg_q.ovr)
      OVR_PASS: event_o = ev_raw;
      OVR_INV:  event_o = ~ev_raw;
      OVR_LOW:  event_o = 1'b0;
      default:  event_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/gpio_evt_enable.sv
module gpio_evt_enable
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_we,
  input  logic [1:0]       en_mode,
  input  logic [NPINS-1:0] en_wdata,
  output logic [NPINS-1:0] en_q
);
  logic [NPINS-1:0] en_d;

  always_comb begin
    case (en_mode)
      MODE_WRITE:  en_d = en_wdata;
      MODE_TOGGLE: en_d = en_q ^ en_wdata;
      MODE_SET:    en_d = en_q | en_wdata;
      default:     en_d = en_q & ~en_wdata;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (en_we) begin
      en_q <= en_d;
    end
  end

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int NPINS    = 28,
  parameter int FILT_LEN = 4,
  parameter int PIDX_W   = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pin_lvl,
  input  logic              reg_we,
  input  logic              reg_tgt,
  input  logic [1:0]        reg_alias,
  input  logic [PIDX_W-1:0] reg_pin,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [NPINS-1:0]  irq_status,
  output logic              irq_req
);
  logic [NPINS-1:0] pin_ev;
  logic [NPINS-1:0] en_q;
  logic             en_we;

  assign en_we = reg_we && reg_tgt;

  gpio_evt_enable #(.NPINS(NPINS)) u_en (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_we    (en_we),
    .en_mode  (reg_alias),
    .en_wdata (reg_wdata[NPINS-1:0]),
    .en_q     (en_q)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic sel_we;
    assign sel_we = reg_we && !reg_tgt && (reg_pin == PIDX_W'(i));

    gpio_evt_pin #(.FILT_LEN(FILT_LEN)) u_pin (
      .clk       (clk),
      .rst_n     (rst_n),
      .lvl_in    (pin_lvl[i]),
      .cfg_we    (sel_we),
      .cfg_mode  (reg_alias),
      .cfg_wdata (reg_wdata),
      .event_o   (pin_ev[i])
    );
  end

  assign irq_status = pin_ev & en_q;
  assign irq_req    = |irq_status;

endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk
  import gpio_irq_pkg::*;
#(
  parameter int NPINS  = 28,
  parameter int PIDX_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic              reg_tgt,
  input logic [1:0]        reg_alias,
  input logic [PIDX_W-1:0] reg_pin,
  input logic [WORD_W-1:0] reg_wdata,
  input logic [NPINS-1:0]  irq_status,
  input logic              irq_req
);
  logic [NPINS-1:0] sh_en, sh_en_d;
  logic [1:0]       sh_ovr   [NPINS];
  logic [1:0]       sh_ovr_d [NPINS];

  always_comb begin
    sh_en_d = sh_en;
    if (reg_we && reg_tgt) begin
      case (reg_alias)
        2'd0:    sh_en_d = reg_wdata[NPINS-1:0];
        2'd1:    sh_en_d = sh_en ^ reg_wdata[NPINS-1:0];
        2'd2:    sh_en_d = sh_en | reg_wdata[NPINS-1:0];
        default: sh_en_d = sh_en & ~reg_wdata[NPINS-1:0];
      endcase
    end
    for (int p = 0; p < NPINS; p++) begin
      sh_ovr_d[p] = sh_ovr[p];
      if (reg_we && !reg_tgt && (int'(reg_pin) == p)) begin
        case (reg_alias)
          2'd0:    sh_ovr_d[p] = reg_wdata[OVR_HI:OVR_LO];
          2'd1:    sh_ovr_d[p] = sh_ovr[p] ^ reg_wdata[OVR_HI:OVR_LO];
          2'd2:    sh_ovr_d[p] = sh_ovr[p] | reg_wdata[OVR_HI:OVR_LO];
          default: sh_ovr_d[p] = sh_ovr[p] & ~reg_wdata[OVR_HI:OVR_LO];
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_en <= '0;
      for (int p = 0; p < NPINS; p++) sh_ovr[p] <= 2'd0;
    end else begin
      sh_en <= sh_en_d;
      for (int p = 0; p < NPINS; p++) sh_ovr[p] <= sh_ovr_d[p];
    end
  end

  // R2
  mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_status & ~sh_en) == '0);

  // R2
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_tgt && reg_alias == 2'd3 && (&reg_wdata[NPINS-1:0]))
      |=> (irq_status == '0));

  // R3
  req_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(irq_status) > 0) |-> irq_req);

  for (genvar p = 0; p < NPINS; p++) begin : g_ovr
    // R8
    force_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sh_ovr[p] == 2'd2) |-> !irq_status[p]);

    // R8
    force_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sh_ovr[p] == 2'd3 && sh_en[p]) |-> irq_status[p]);
  end

endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NPINS(NPINS), .PIDX_W(PIDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_we     (reg_we),
  .reg_tgt    (reg_tgt),
  .reg_alias  (reg_alias),
  .reg_pin    (reg_pin),
  .reg_wdata  (reg_wdata),
  .irq_status (irq_status),
  .irq_req    (irq_req)
);

// File: tb/gpio_irq_bank_test.sv
module gpio_irq_bank_test;
  localparam int NP = 6;
  localparam int FL = 4;
  localparam int PW = 3;
  localparam int T_CTRL = 0, T_EN = 1;
  localparam int A_WR = 0, A_XOR = 1, A_SET = 2, A_CLR = 3;
  localparam logic [31:0] CFG_KEEP = 32'hCFF0_0000;

  logic          clk, rst_n;
  logic [NP-1:0] pin_lvl;
  logic          reg_we, reg_tgt;
  logic [1:0]    reg_alias;
  logic [PW-1:0] reg_pin;
  logic [31:0]   reg_wdata;
  logic [NP-1:0] irq_status;
  logic          irq_req;

  int checks, fails;
  bit done;

  gpio_irq_bank #(.NPINS(NP), .FILT_LEN(FL)) uut (
    .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .reg_we(reg_we),
    .reg_tgt(reg_tgt), .reg_alias(reg_alias), .reg_pin(reg_pin),
    .reg_wdata(reg_wdata), .irq_status(irq_status), .irq_req(irq_req)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // behavioural reference
  logic [31:0] m_cfg [NP];
  logic [3:0]  m_lat [NP];
  bit          m_prev [NP];
  bit          m_filt [NP];
  int          m_cnt  [NP];
  logic [31:0] m_en;

  function automatic logic [31:0] merge(logic [31:0] c, logic [31:0] w, int a);
    if (a == A_WR)  return w;
    if (a == A_XOR) return c ^ w;
    if (a == A_SET) return c | w;
    return c & ~w;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NP; p++) begin
        m_cfg[p] = 0; m_lat[p] = 0; m_prev[p] = 0; m_filt[p] = 0; m_cnt[p] = 0;
      end
      m_en = 0;
    end else begin
      for (int p = 0; p < NP; p++) begin
        bit l, fn, hit, kill;
        logic [3:0] det, ena;
        l = pin_lvl[p];
        fn = m_filt[p];
        if (l != m_filt[p]) begin
          if (m_cnt[p] == FL - 1) begin fn = l; m_cnt[p] = 0; end
          else m_cnt[p]++;
        end else m_cnt[p] = 0;
        det = {fn & !m_filt[p], !fn & m_filt[p], l & !m_prev[p], !l & m_prev[p]};
        ena = {m_cfg[p][25], m_cfg[p][24], m_cfg[p][21], m_cfg[p][20]};
        hit = reg_we && reg_tgt == T_CTRL && int'(reg_pin) == p;
        kill = hit && reg_alias != A_CLR && reg_wdata[28];
        m_lat[p] = (kill ? 4'b0 : m_lat[p]) | (det & ena);
        if (hit) m_cfg[p] = merge(m_cfg[p], reg_wdata, reg_alias) & CFG_KEEP;
        m_prev[p] = l;
        m_filt[p] = fn;
      end
      if (reg_we && reg_tgt == T_EN)
        m_en = merge(m_en, reg_wdata, reg_alias) & ((32'd1 << NP) - 1);
    end
  end

  function automatic bit model_bit(int p);
    bit ev;
    logic [31:0] c;
    c = m_cfg[p];
    ev = (|m_lat[p]) | (c[22] & !pin_lvl[p]) | (c[23] & pin_lvl[p])
       | (c[26] & !m_filt[p]) | (c[27] & m_filt[p]);
    case (c[31:30])
      2'd0: ev = ev;
      2'd1: ev = !ev;
      2'd2: ev = 0;
      default: ev = 1;
    endcase
    return ev & m_en[p];
  endfunction

  // per-cycle comparison, away from the active edge
  always begin
    @(negedge clk);
    #3;
    if (rst_n) begin
      logic [NP-1:0] exp_s;
      for (int p = 0; p < NP; p++) exp_s[p] = model_bit(p);
      checks++;
      if (irq_status !== exp_s) begin
        fails++;
        $display("FAIL R2 status per-cycle: actual %b expected %b at %0t", irq_status, exp_s, $time);
      end
      checks++;
      if (irq_req !== (|exp_s)) begin
        fails++;
        $display("FAIL R3 request per-cycle: actual %b expected %b at %0t", irq_req, |exp_s, $time);
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(int tgt, int al, int pin, logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_tgt = tgt[0]; reg_alias = al[1:0]; reg_pin = pin[PW-1:0]; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic look(string tag, int p, bit exp);
    #3;
    checks++;
    if (irq_status[p] !== exp) begin
      fails++;
      $display("FAIL %s pin %0d: actual %b expected %b", tag, p, irq_status[p], exp);
    end
  endtask

  task automatic look_req(string tag, bit exp);
    #3;
    checks++;
    if (irq_req !== exp) begin
      fails++;
      $display("FAIL %s irq_req: actual %b expected %b", tag, irq_req, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [NP-1:0] snap;
    rst_n = 0; pin_lvl = 0; reg_we = 0; reg_tgt = 0; reg_alias = 0; reg_pin = 0; reg_wdata = 0;
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R1 reset state
    #3;
    checks++;
    if (irq_status !== '0 || irq_req !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset: actual %b/%b expected 0/0", irq_status, irq_req);
    end

    wr(T_EN, A_SET, 0, 32'h3f);

    // R4 rising edge latches and holds
    wr(T_CTRL, A_WR, 0, 32'd1 << 21);
    tick(); pin_lvl[0] = 1;
    tick(); look("R4 rise latch", 0, 1);
    tick(); pin_lvl[0] = 0;
    tick(); tick(); look("R4 hold", 0, 1);
    wr(T_CTRL, A_SET, 0, 32'd1 << 28); look("R7 clear cmd", 0, 0);

    // R4 both edges
    wr(T_CTRL, A_WR, 1, 32'd3 << 20);
    tick(); pin_lvl[1] = 1;
    tick(); look("R4 both rise", 1, 1);
    wr(T_CTRL, A_SET, 1, 32'd1 << 28); look("R7 clear", 1, 0);
    tick(); pin_lvl[1] = 0;
    tick(); look("R4 both fall", 1, 1);
    wr(T_CTRL, A_SET, 1, 32'd1 << 28);

    // R5 level follows pin
    wr(T_CTRL, A_WR, 2, 32'd1 << 23);
    tick(); pin_lvl[2] = 1; look("R5 level high", 2, 1);
    tick(); pin_lvl[2] = 0; look("R5 not latched", 2, 0);

    // R6 filtered rise
    wr(T_CTRL, A_WR, 3, 32'd1 << 25);
    tick(); pin_lvl[3] = 1;
    tick(); tick(); tick(); look("R6 before hold", 3, 0);
    tick(); look("R6 after hold", 3, 1);
    tick(); pin_lvl[3] = 0;
    repeat (5) tick();
    wr(T_CTRL, A_SET, 3, 32'd1 << 28); look("R7 filt clear", 3, 0);
    tick(); pin_lvl[3] = 1;
    tick(); tick(); pin_lvl[3] = 0;
    repeat (6) tick();
    look("R6 short pulse", 3, 0);

    // R8 override, R9 modes on control word
    wr(T_CTRL, A_WR, 4, 32'd3 << 30); look("R8 force high", 4, 1);
    wr(T_CTRL, A_WR, 4, 32'd1 << 30); look("R8 invert idle", 4, 1);
    wr(T_CTRL, A_WR, 4, (32'd2 << 30) | (32'd1 << 22)); look("R8 force low", 4, 0);
    wr(T_CTRL, A_XOR, 4, 32'd3 << 30); look("R9 toggle to invert", 4, 0);
    wr(T_CTRL, A_CLR, 4, 32'd1 << 22); look("R9 clear mode", 4, 1);
    wr(T_CTRL, A_WR, 4, 32'd3 << 30); look_req("R3 any set", 1);

    // R2 enable masking and toggle
    wr(T_EN, A_CLR, 0, 32'd1 << 4); look("R2 masked", 4, 0);
    wr(T_EN, A_XOR, 0, 32'd1 << 4); look("R2 toggled on", 4, 1);

    // R7 edge in same cycle as clear command wins
    wr(T_CTRL, A_WR, 5, 32'd1 << 21);
    @(negedge clk);
    pin_lvl[5] = 1;
    reg_we = 1; reg_tgt = 0; reg_alias = 2'(A_SET); reg_pin = 3'd5; reg_wdata = 32'd1 << 28;
    @(negedge clk);
    reg_we = 0;
    look("R7 edge wins", 5, 1);

    // R9 out-of-range pin index ignored
    tick();
    #3 snap = irq_status;
    wr(T_CTRL, A_WR, 6, 32'd2 << 30);
    wr(T_CTRL, A_WR, 7, 32'hffff_ffff);
    #3;
    checks++;
    if (irq_status !== snap) begin
      fails++;
      $display("FAIL R9 bad index: actual %b expected %b", irq_status, snap);
    end

    // R2 write mode clears every enable
    wr(T_EN, A_WR, 0, 32'd0); look_req("R2 all disabled", 0);
    tick();

    done = 1;
    summary();
    $finish;
  end

endmodule